// File: doc/BRIEF.md
# Eight-Bit Window Shift and Rotate Unit

This block is the shift and rotate stage of a small ALU. It takes an operand, a shift amount and a 3-bit operation code. In the same cycle it returns the operand shifted or rotated in one of seven ways. Left shifts can fill with zeros or with ones. Right shifts can fill with zeros, with ones, or with copies of the sign bit. Rotates can go left or right. There is no clock and no state: the result depends only on the current inputs.

Every operation uses one datapath. The operand and a per-operation fill pattern are written into a window of 2·W−1 bits. A one-hot select line then extracts W consecutive bits from that window. For a right operation the select index equals the shift amount. For a left operation the index is the ones complement of the amount, so the same right-extracting tap produces a left shift. Each window bit belongs to one of three groups: bits above the operand's right-aligned position, the single middle bit, and the bits below it. Each group has its own small source selector, so no bit needs a full seven-way multiplexer.

The operand width is a parameter, 8 by default. The amount width is derived from it. A parameter also picks how the tap is built.

Top module: `shf_unit`

## Requirements
- R1: The operation code on `op_i` is decoded as 000 left-zero-fill, 001 left-one-fill, 010 rotate-left, 011 right-zero-fill, 100 right-one-fill, 101 arithmetic-right, 110 rotate-right, and 111 pass-through.
- R2: Left shifts (codes 000 and 001) move the operand up by `amt_i` places. The vacated low bits are filled with 0 for code 000 and with 1 for code 001.
- R3: Rotate-left (code 010) returns the operand rotated up by `amt_i` places. Bits leaving the top re-enter at bit 0.
- R4: Right shifts (codes 011 and 100) move the operand down by `amt_i` places. The vacated high bits are filled with 0 for code 011 and with 1 for code 100.
- R5: Arithmetic-right (code 101) moves the operand down by `amt_i` places. The vacated high bits are filled with copies of the operand's bit 7, so bit 7 of the result always equals bit 7 of the operand.
- R6: Rotate-right (code 110) returns the operand rotated down by `amt_i` places. Bits leaving bit 0 re-enter at the top.
- R7: An amount of 0 returns the operand unchanged for every operation code.
- R8: Code 111 returns the operand unchanged, whatever the amount.
- R9: At the largest amount (7), each shift keeps only one operand bit and fills the other seven positions. Rotates at amount 7 equal a rotate by one place in the opposite direction.
- R10: The result is purely combinational. It reflects new inputs within the same clock period, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | DATA_W (8) | Operand to shift or rotate |
| amt_i | input | log2(DATA_W) (3) | Shift or rotate amount |
| op_i | input | 3 | Operation code (see R1) |
| res_o | output | DATA_W (8) | Shifted or rotated result |

## Verification
The hardest case to reach is a window bit that only one operation and one amount ever route to the output. An example is the topmost window bit under arithmetic-right, which appears only at amount 7. Another is the lowest fill bit under left-one-fill, which appears only when the amount is non-zero and the one's-complemented select index is small. A short vector list cannot be sure to touch these. So after a table of hand-worked corner vectors, the stimulus sweeps every operation code against every amount and every operand value. The sweep compares each result with a behavioural shift model written with ordinary shift operators. Every window bit under every fill pattern therefore reaches the output at least once.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [2:0] {
      OP_SHL_Z = 3'd0,
      OP_SHL_O = 3'd1,
      OP_ROL   = 3'd2,
      OP_SHR_Z = 3'd3,
      OP_SHR_O = 3'd4,
      OP_SHR_A = 3'd5,
      OP_ROR   = 3'd6,
      OP_THRU  = 3'd7
   } shf_op_e;

   // Left-moving operations read the window with an inverted index.
   function automatic logic op_is_left(input shf_op_e op);
      return (op == OP_SHL_Z) || (op == OP_SHL_O) || (op == OP_ROL);
   endfunction

endpackage

// File: rtl/shf_sel_dec.sv
module shf_sel_dec
   import shf_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic [CNT_W-1:0]  amt_i,
   input  shf_op_e           op_i,
   output logic [DATA_W-1:0] sel_o
);

   logic [CNT_W-1:0] eff_idx;

   // Pass-through pins the tap at index 0; left ops complement the amount.
   always_comb begin
      if (op_i == OP_THRU)
         eff_idx = '0;
      else if (op_is_left(op_i))
         eff_idx = ~amt_i;
      else
         eff_idx = amt_i;
   end

   genvar k;
   for (k = 0; k < DATA_W; k++) begin : g_line
      assign sel_o[k] = (eff_idx == CNT_W'(k));
   end

endmodule

// File: rtl/shf_win_fill.sv
module shf_win_fill
   import shf_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WIN_W = 2*DATA_W - 1,
   localparam int MSB   = DATA_W - 1
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  shf_op_e           op_i,
   output logic [WIN_W-1:0]  win_o
);

   logic left;
   assign left = op_is_left(op_i);

   genvar i;

   // Lower group: fill constants or the operand's upper bits (left),
   // the operand itself (right).
   for (i = 0; i < MSB; i++) begin : g_lo
      logic lo_left_src;
      assign lo_left_src = (op_i == OP_SHL_Z) ? 1'b0 :
                           (op_i == OP_SHL_O) ? 1'b1 :
                                                opnd_i[i+1];
      assign win_o[i] = left ? lo_left_src : opnd_i[i];
   end

   // Middle bit: two sources only.
   assign win_o[MSB] = left ? opnd_i[0] : opnd_i[MSB];

   // Upper group: operand (left), or the fill for right-moving ops.
   for (i = DATA_W; i < WIN_W; i++) begin : g_hi
      logic hi_right_src;
      assign hi_right_src = (op_i == OP_SHR_O) ? 1'b1 :
                            (op_i == OP_SHR_A) ? opnd_i[MSB] :
                            (op_i == OP_ROR)   ? opnd_i[i-DATA_W] :
                                                 1'b0;
      assign win_o[i] = left ? opnd_i[i-MSB] : hi_right_src;
   end

   // R5: under arithmetic-right, every fill bit copies the sign
   always_comb begin
      if (!$isunknown({op_i, opnd_i}) && op_i == OP_SHR_A)
         AST_SIGN_FILL: assert (win_o[WIN_W-1:DATA_W] == {(DATA_W-1){opnd_i[MSB]}}); // R5
   end

endmodule

// File: rtl/shf_win_tap.sv
module shf_win_tap #(
   parameter int DATA_W    = 8,
   parameter int TAP_STYLE = 0,
   localparam int WIN_W = 2*DATA_W - 1,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic [WIN_W-1:0]  win_i,
   input  logic [DATA_W-1:0] sel_i,
   output logic [DATA_W-1:0] res_o
);

   genvar j, x;

   if (TAP_STYLE == 0) begin : g_andor
      // Each output bit ORs the window bits gated by their select line.
      for (j = 0; j < DATA_W; j++) begin : g_bit
         logic [DATA_W-1:0] terms;
         for (x = 0; x < DATA_W; x++) begin : g_term
            assign terms[x] = sel_i[x] & win_i[x+j];
         end
         assign res_o[j] = |terms;
      end
   end else begin : g_index
      // Encode the one-hot select back to a binary index, then slice.
      logic [CNT_W-1:0] idx;
      always_comb begin
         idx = '0;
         for (int n = 0; n < DATA_W; n++)
            if (sel_i[n]) idx = idx | CNT_W'(n);
      end
      assign res_o = win_i[idx +: DATA_W];
   end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int TAP_STYLE = 0,
   localparam int CNT_W = $clog2(DATA_W),
   localparam int WIN_W = 2*DATA_W - 1
) (
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [CNT_W-1:0]  amt_i,
   input  logic [2:0]        op_i,
   output logic [DATA_W-1:0] res_o
);

   // Elaboration-time parameter checks.
   if (DATA_W < 2 || (1 << CNT_W) != DATA_W) begin : g_bad_width
      $error("shf_unit: DATA_W must be a power of two of at least 2");
   end
   if (TAP_STYLE != 0 && TAP_STYLE != 1) begin : g_bad_style
      $error("shf_unit: TAP_STYLE must be 0 or 1");
   end

   shf_op_e           op;
   logic [DATA_W-1:0] sel;
   logic [WIN_W-1:0]  win;

   assign op = shf_op_e'(op_i);

   shf_sel_dec #(.DATA_W(DATA_W)) u_dec (
      .amt_i (amt_i),
      .op_i  (op),
      .sel_o (sel)
   );

   shf_win_fill #(.DATA_W(DATA_W)) u_fill (
      .opnd_i (opnd_i),
      .op_i   (op),
      .win_o  (win)
   );

   shf_win_tap #(.DATA_W(DATA_W), .TAP_STYLE(TAP_STYLE)) u_tap (
      .win_i (win),
      .sel_i (sel),
      .res_o (res_o)
   );

   always_comb begin
      if (!$isunknown({op_i, amt_i, opnd_i})) begin
         AST_SEL_ONEHOT: assert ($onehot(sel));                              // R1
         if (amt_i == '0)
            AST_ZERO_AMT: assert (res_o == opnd_i);                          // R7
         if (op == OP_THRU)
            AST_THRU: assert (res_o == opnd_i);                              // R8
         if (op == OP_ROL || op == OP_ROR)
            AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(opnd_i)); // R3
         if (op == OP_SHL_Z)
            AST_SHL_LOW_ZERO: assert ((res_o & ~({DATA_W{1'b1}} << amt_i)) == '0); // R2
         if (op == OP_SHR_O)
            AST_SHR_HIGH_ONE: assert ((res_o | ({DATA_W{1'b1}} >> amt_i)) == {DATA_W{1'b1}}); // R4
         if (op == OP_SHR_A)
            AST_ASR_MSB: assert (res_o[DATA_W-1] == opnd_i[DATA_W-1]);       // R5
      end
   end

endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opnd;
   logic [2:0] amt;
   logic [2:0] op;
   logic [7:0] res;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk; // 250 MHz

   shf_unit u0 (
      .opnd_i (opnd),
      .amt_i  (amt),
      .op_i   (op),
      .res_o  (res)
   );

   // Fields: op[21:19] amt[18:16] operand[15:8] expected[7:0]
   localparam int NVEC = 14;
   localparam logic [21:0] VEC [NVEC] = '{
      {3'd0, 3'd1, 8'h81, 8'h02},   // R2 left zero fill
      {3'd1, 3'd3, 8'h81, 8'h0F},   // R2 left one fill
      {3'd2, 3'd1, 8'h81, 8'h03},   // R3 rotate left
      {3'd2, 3'd7, 8'h81, 8'hC0},   // R9 rotate left by 7
      {3'd3, 3'd4, 8'hF0, 8'h0F},   // R4 right zero fill
      {3'd4, 3'd2, 8'h04, 8'hC1},   // R4 right one fill
      {3'd5, 3'd3, 8'h80, 8'hF0},   // R5 negative arithmetic
      {3'd5, 3'd3, 8'h70, 8'h0E},   // R5 positive arithmetic
      {3'd6, 3'd1, 8'h01, 8'h80},   // R6 rotate right
      {3'd6, 3'd4, 8'hA5, 8'h5A},   // R6 nibble swap
      {3'd0, 3'd7, 8'hFF, 8'h80},   // R9 left zero fill by 7
      {3'd4, 3'd7, 8'h00, 8'hFE},   // R9 right one fill by 7
      {3'd7, 3'd5, 8'h3C, 8'h3C},   // R8 pass-through ignores amount
      {3'd1, 3'd0, 8'h55, 8'h55}    // R7 zero amount
   };

   function automatic logic [7:0] model(input logic [2:0] o, input logic [2:0] c,
                                        input logic [7:0] a);
      logic [15:0] dbl;
      logic [7:0]  m;
      case (o)
         3'd0: return a << c;
         3'd1: begin m = 8'hFF << c; return (a << c) | ~m; end
         3'd2: begin dbl = {a, a} << c; return dbl[15:8]; end
         3'd3: return a >> c;
         3'd4: begin m = 8'hFF >> c; return (a >> c) | ~m; end
         3'd5: return 8'($signed(a) >>> c);
         3'd6: begin dbl = {a, a} >> c; return dbl[7:0]; end
         default: return a;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] o, input logic [2:0] c);
      if (c == 3'd0) return "R7";
      case (o)
         3'd0, 3'd1: return "R2";
         3'd2: return "R3";
         3'd3, 3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] exp);
      n_vec++;
      if (res !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d amt=%0d opnd=%h got=%h expected=%h",
                  tag, op, amt, opnd, res, exp);
      end
   endtask

   // Inputs change after a rising edge; the result is sampled at the next
   // falling edge in the same period (R10: no register on the path).
   task automatic apply(input logic [2:0] o, input logic [2:0] c,
                        input logic [7:0] a, input logic [7:0] exp,
                        input string tag);
      @(posedge clk);
      #1;
      op = o; amt = c; opnd = a;
      @(negedge clk);
      check(tag, exp);
   endtask

   initial begin
      op = 3'd0; amt = 3'd0; opnd = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7", 8'h00);   // reset state: all-zero inputs give zero
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++)
         apply(VEC[v][21:19], VEC[v][18:16], VEC[v][15:8], VEC[v][7:0], "R1");

      // R10: the result follows a change of operation code inside one period
      apply(3'd3, 3'd1, 8'h80, 8'h40, "R10");
      apply(3'd0, 3'd1, 8'h80, 8'h00, "R10");

      // R8: pass-through under every amount
      for (int c = 0; c < 8; c++)
         apply(3'd7, 3'(c), 8'hC3, 8'hC3, "R8");

      // Exhaustive sweep against the behavioural model
      for (int o = 0; o < 7; o++)
         for (int c = 0; c < 8; c++)
            for (int a = 0; a < 256; a++)
               apply(3'(o), 3'(c), 8'(a), model(3'(o), 3'(c), 8'(a)),
                     tag_of(3'(o), 3'(c)));

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog: run did not finish, got=timeout expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule